// File: doc/BRIEF.md
# I2C Register-File Target with Auto-Incrementing Pointer

This block is an I2C target that gives a bus controller byte access to a small bank of 8-bit control registers. The registers themselves sit outside the block. The block drives a register address, a write strobe and write data, and it takes the read data back on a combinational read port. A single internal pointer selects the register. A write transaction loads the pointer from its first data byte. Any further bytes in that write are stored at consecutive addresses.

A read transaction carries no pointer byte. It starts returning data at whatever address the pointer already holds. To read from a chosen address, the controller first sends a short write that holds only the pointer byte and then a STOP. It then issues the read. Both the pointer and the data transfers step through the bank and wrap at its top.

SCL and SDA are sampled with the system clock. Each line passes through a two-flop synchroniser before START, STOP and clock edges are detected. SDA is driven open-drain through a single drive-low enable. A strap input supplies the lowest device-address bit, so two targets can share one bus.

Top module: `i2c_regmap_target`

## Requirements
- R1: The target answers the 7-bit address {1,0,0,1,1,1,strap}, followed by the R/W bit (0 = write, 1 = read), so the address byte is 0x9C/0x9D with strap low and 0x9E/0x9F with strap high. It acknowledges by holding SDA low during the ninth clock.
- R2: An address byte that does not match gets no acknowledge, and the rest of that transaction causes no register write.
- R3: In a write, the byte after the address is the pointer byte. It is acknowledged, and its low log2(REG_COUNT) bits are loaded into the pointer (with 16 registers, 0x13 selects register 3).
- R4: Every data byte of a write is acknowledged. It produces a one-cycle reg_we_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte.
- R5: After each written byte the pointer increments, and it wraps from REG_COUNT-1 to 0.
- R6: A write that ends with STOP right after the pointer byte's acknowledge writes no register, and it leaves the pointer at the new value for a later read.
- R7: A read returns the register at the current pointer, MSB first. Each byte read increments the pointer, with wrap, and a controller ACK after a byte requests the next register.
- R8: A controller NO-ACK ends the read. The target leaves SDA released, and after STOP the pointer indicates the register after the last byte sent.
- R9: A START or repeated START at any point returns the target to address reception. A read may follow a pointer write through a repeated START.
- R10: After reset, SDA is released, reg_we_o is low and the pointer is 0.
- R11: The target only begins pulling SDA low while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| addr_strap_i | input | 1 | Static strap setting the low device-address bit |
| reg_addr_o | output | ADDR_W | Register address (the pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o, combinational |

## Verification
Most internal faults show at the bus within one byte. A wrong bit count or state shifts or suppresses the ninth-clock acknowledge. A wrong pointer puts the strobe on the wrong address, or returns the wrong register, in the very next data byte. Pointer faults that only show up later, such as a missing wrap, a missed increment or a pointer clobbered by a STOP, are made visible through reg_addr_o right after STOP and through data read back in a following read. Register contents are compared through a bench-side register bank that is filled only by the strobe.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_MAP,
        ST_ACK_MAP,
        ST_WR,
        ST_ACK_WR,
        ST_RD,
        ST_RACK
    } i2c_state_e;

    localparam int unsigned BITS_PER_BYTE = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    // data edges only count as bus conditions while the clock stays high
    assign start_evt = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_evt  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2c_regmap_fsm.sv
module i2c_regmap_fsm
    import i2c_regmap_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter logic [5:0]  DEV_ADDR_HI = 6'b100111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_s,
    input  logic              strap,
    input  logic [7:0]        rdata,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] map,
    output logic [7:0]        wdata,
    output logic              we
);
    localparam logic [3:0] LAST_BIT = 4'(BITS_PER_BYTE);

    typedef struct packed {
        i2c_state_e        state;
        logic [3:0]        cnt;
        logic [7:0]        shift;
        logic [7:0]        tx;
        logic [ADDR_W-1:0] map;
        logic              rd;
        logic              ack;
        logic              oe;
        logic              we;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_evt) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else if (start_evt) begin
            d.state = ST_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else begin
            unique case (q.state)
                ST_ADDR, ST_MAP, ST_WR: begin
                    if (scl_rise && q.cnt != LAST_BIT) begin
                        d.shift = {q.shift[6:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        if (q.state == ST_ADDR) begin
                            if (q.shift[7:1] == {DEV_ADDR_HI, strap}) begin
                                d.state = ST_ACK_ADDR;
                                d.rd    = q.shift[0];
                                d.oe    = 1'b1;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else if (q.state == ST_MAP) begin
                            d.map   = q.shift[ADDR_W-1:0];
                            d.state = ST_ACK_MAP;
                            d.oe    = 1'b1;
                        end else begin
                            d.we    = 1'b1;
                            d.state = ST_ACK_WR;
                            d.oe    = 1'b1;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.state = ST_RD;
                            d.tx    = rdata;
                            d.oe    = ~rdata[7];
                        end else begin
                            d.state = ST_MAP;
                            d.oe    = 1'b0;
                        end
                    end
                end
                ST_ACK_MAP: begin
                    if (scl_fall) begin
                        d.state = ST_WR;
                        d.oe    = 1'b0;
                    end
                end
                ST_ACK_WR: begin
                    if (scl_fall) begin
                        d.state = ST_WR;
                        d.oe    = 1'b0;
                        d.map   = q.map + 1'b1;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.state = ST_RACK;
                            d.oe    = 1'b0;
                            d.cnt   = '0;
                            d.map   = q.map + 1'b1;
                        end else begin
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.oe  = ~q.tx[6];
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.ack) begin
                            d.state = ST_RD;
                            d.tx    = rdata;
                            d.oe    = ~rdata[7];
                            d.cnt   = '0;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign map    = q.map;
    assign wdata  = q.shift;
    assign we     = q.we;
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target #(
    parameter int unsigned REG_COUNT   = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [5:0]  DEV_ADDR_HI = 6'b100111,
    localparam int unsigned ADDR_W     = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              addr_strap_i,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [7:0]        reg_wdata_o,
    output logic              reg_we_o,
    input  logic [7:0]        reg_rdata_i
);
    logic [1:0] line_raw, line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_evt, stop_evt;

    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[g]),
            .dout (line_s[g])
        );
    end

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2c_regmap_fsm #(
        .ADDR_W     (ADDR_W),
        .DEV_ADDR_HI(DEV_ADDR_HI)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .sda_s    (sda_s),
        .strap    (addr_strap_i),
        .rdata    (reg_rdata_i),
        .sda_oe   (sda_oe_o),
        .map      (reg_addr_o),
        .wdata    (reg_wdata_o),
        .we       (reg_we_o)
    );
endmodule

// File: rtl/i2c_regmap_target_chk.sv
module i2c_regmap_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_evt,
    input logic stop_evt,
    input logic sda_oe_o,
    input logic reg_we_o
);
    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);                                      // R4
    AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> sda_oe_o);                                       // R4
    AST_DRIVE_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);                                  // R11
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe_o);                                     // R9
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_oe_o && !reg_we_o));                       // R8
endmodule

bind i2c_regmap_target i2c_regmap_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_oe_o (sda_oe_o),
    .reg_we_o (reg_we_o)
);

// File: tb/i2c_regmap_target_bench.sv
`timescale 1ns/1ps
module i2c_regmap_target_bench;
    localparam int REGS  = 16;
    localparam int AW    = 4;
    localparam int Q     = 8;
    localparam int LIMIT = 150000;
    localparam int NV    = 6;
    localparam logic [7:0] VEC_MAP  [NV] = '{8'h00, 8'h05, 8'h0A, 8'h0F, 8'h13, 8'h07};
    localparam logic [7:0] VEC_DATA [NV] = '{8'h5A, 8'hC3, 8'h01, 8'hFF, 8'h80, 8'h7E};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1, strap = 1'b0;
    logic sda_oe, reg_we, sda_line;
    logic [AW-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] bank [REGS];
    int checks = 0, errors = 0, we_count = 0, cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line  = sda_drv & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    i2c_regmap_target u_i2c_regmap_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_strap_i(strap), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            we_count <= we_count + 1;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected < %0d", cyc, LIMIT);
            done = 1'b1;
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq();
        sda_drv = 1'b0; wq(); scl_drv = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq();
        sda_drv = 1'b1; wq(2);
    endtask

    task automatic clock_bit(input logic b);
        sda_drv = b; wq(); scl_drv = 1'b1; wq(2); scl_drv = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq();
        acked = !sda_line;
        wq(); scl_drv = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_drv = 1'b1; wq();
            b[i] = sda_line;
            wq(); scl_drv = 1'b0; wq();
        end
        clock_bit(!give_ack);
        sda_drv = 1'b1;
    endtask

    task automatic set_map(input logic [7:0] adr, input logic [7:0] m, input string req);
        bit a;
        bus_start();
        send_byte(adr, a);   check(a, "R1", "address ack", a, 1);
        send_byte(m, a);     check(a, req, "pointer ack", a, 1);
        bus_stop();
    endtask

    initial begin
        bit a;
        logic [7:0] rb;
        int wc;
        for (int i = 0; i < REGS; i++) bank[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wq();
        // R10 reset state
        check(sda_oe == 1'b0, "R10", "sda released", sda_oe, 0);
        check(reg_we == 1'b0, "R10", "no strobe", reg_we, 0);
        check(reg_addr == 0, "R10", "pointer zero", reg_addr, 0);

        // vector table: single write, pointer-only write, single read
        for (int v = 0; v < NV; v++) begin
            bus_start();
            send_byte(8'h9C, a);          check(a, "R1", "write address ack", a, 1);
            send_byte(VEC_MAP[v], a);     check(a, "R3", "pointer ack", a, 1);
            send_byte(VEC_DATA[v], a);    check(a, "R4", "data ack", a, 1);
            bus_stop();
            check(bank[VEC_MAP[v] % REGS] == VEC_DATA[v], "R4", "register written",
                  bank[VEC_MAP[v] % REGS], VEC_DATA[v]);
            set_map(8'h9C, VEC_MAP[v], "R6");
            check(reg_addr == VEC_MAP[v] % REGS, "R3", "pointer truncated", reg_addr, VEC_MAP[v] % REGS);
            bus_start();
            send_byte(8'h9D, a);          check(a, "R1", "read address ack", a, 1);
            recv_byte(1'b0, rb);
            bus_stop();
            check(rb == VEC_DATA[v], "R7", "read data", rb, VEC_DATA[v]);
        end

        // R5 burst write with wrap
        bus_start();
        send_byte(8'h9C, a);
        send_byte(8'h0E, a);
        send_byte(8'hA1, a);
        send_byte(8'hA2, a);
        send_byte(8'hA3, a);        check(a, "R5", "third data ack", a, 1);
        bus_stop();
        check(bank[14] == 8'hA1, "R5", "reg 14", bank[14], 8'hA1);
        check(bank[15] == 8'hA2, "R5", "reg 15", bank[15], 8'hA2);
        check(bank[0]  == 8'hA3, "R5", "wrapped reg 0", bank[0], 8'hA3);
        check(reg_addr == 1, "R5", "pointer after wrap", reg_addr, 1);

        // R6 pointer-only write touches no register
        wc = we_count;
        set_map(8'h9C, 8'h08, "R6");
        check(we_count == wc, "R6", "no write strobe", we_count, wc);
        check(reg_addr == 8, "R6", "pointer kept", reg_addr, 8);

        // R7/R8 burst read with wrap, NO-ACK ends it
        set_map(8'h9C, 8'h0F, "R6");
        bus_start();
        send_byte(8'h9D, a);
        recv_byte(1'b1, rb); check(rb == 8'hA2, "R7", "burst byte 0", rb, 8'hA2);
        recv_byte(1'b1, rb); check(rb == 8'hA3, "R7", "burst byte 1 wrapped", rb, 8'hA3);
        recv_byte(1'b0, rb); check(rb == bank[1], "R7", "burst byte 2", rb, bank[1]);
        check(sda_oe == 1'b0, "R8", "released after no-ack", sda_oe, 0);
        bus_stop();
        check(reg_addr == 2, "R8", "pointer after read", reg_addr, 2);

        // R2 wrong address ignored
        wc = we_count;
        bus_start();
        send_byte(8'h9E, a);        check(!a, "R2", "no ack for foreign address", a, 0);
        send_byte(8'h03, a);        check(!a, "R2", "no ack on later byte", a, 0);
        send_byte(8'h55, a);
        bus_stop();
        check(we_count == wc, "R2", "no write", we_count, wc);
        check(reg_addr == 2, "R2", "pointer unchanged", reg_addr, 2);

        // R1 strap high selects 0x9E
        strap = 1'b1;
        wq();
        bus_start();
        send_byte(8'h9E, a);        check(a, "R1", "strap-high ack", a, 1);
        send_byte(8'h06, a);
        send_byte(8'h3C, a);
        bus_stop();
        check(bank[6] == 8'h3C, "R1", "strap-high write", bank[6], 8'h3C);
        bus_start();
        send_byte(8'h9C, a);        check(!a, "R1", "old address ignored", a, 0);
        bus_stop();
        strap = 1'b0;
        wq();

        // R9 repeated START after pointer byte turns into read
        bus_start();
        send_byte(8'h9C, a);
        send_byte(8'h05, a);
        bus_start();
        send_byte(8'h9D, a);        check(a, "R9", "read after repeated start", a, 1);
        recv_byte(1'b0, rb);
        bus_stop();
        check(rb == 8'hC3, "R9", "repeated start read", rb, 8'hC3);

        // R9 START in the middle of a data byte aborts it
        wc = we_count;
        bus_start();
        send_byte(8'h9C, a);
        send_byte(8'h0A, a);
        clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1);
        bus_start();
        send_byte(8'h9C, a);        check(a, "R9", "address after mid-byte start", a, 1);
        bus_stop();
        check(we_count == wc, "R9", "aborted byte not written", we_count, wc);
        check(bank[10] == 8'h01, "R9", "reg 10 intact", bank[10], 8'h01);

        done = 1'b1;
        finish_run();
    end
endmodule